// File: doc/BRIEF.md
# Event pattern RAM sequencer

This block plays back canned events held in a 4096-word pattern memory split into four banks of 1024 words. A host loads the memory while transmission is off, using an auto-incrementing address counter, and can read it back the same way. Once transmission is on, each trigger carries a 2-bit bank number that is queued in a small trigger queue. For each queued trigger the sequencer walks one event in the named bank, decodes the control bits of each word, and pushes tagged entries toward a downstream output FIFO. It also hands each event's start delay to a separate delay handler.

Every bank keeps its events at the same offsets. One shared offset counter therefore decides which event is replayed: the nth trigger gets the nth event of whatever bank it names. A closing word that carries the terminator bit sends the next trigger back to the first event. Output timing, gap timing and bus decoding are handled by neighbouring blocks.

Top module: `evt_pattern_seq`

## Requirements
- R1: After reset, transmission is off: `trig_ready`, `out_push`, `dly_valid` and `host_rvalid` are all 0.
- R2: While `tx_en` is 0, `host_addr_clr` sets the host address to 0. `host_wr` writes `host_wdata` at that address and then increments it. `host_rd` returns the word at that address on `host_rdata`, with `host_rvalid` high one cycle later, and then increments the address. The address wraps from 4095 to 0.
- R3: While `tx_en` is 1, the host strobes have no effect: memory is not written, `host_rvalid` stays 0, and the host address does not move.
- R4: Triggers are accepted only while `tx_en` is 1 and the trigger queue has room (`trig_ready`). A trigger offered while transmission is off is dropped and produces no output.
- R5: Word layout: data is in bits 22..0, and the control bits are delay=23, gap=24, empty=25, end-of-event=26, terminator=27. While transmission is on, the read address is {bank, offset}: the bank number forms the top 2 bits and a shared 10-bit offset forms the rest. Events are replayed in trigger order.
- R6: A delay word at the start of an event raises `dly_valid` for one cycle, with `dly_value` set to its bits 11..0 and `dly_buf` set to the bank. The word is never pushed. `dly_valid` is high in the third clock cycle after the cycle in which the trigger is accepted into an idle, empty trigger queue.
- R7: A gap word is pushed with `out_gap`=1 and `out_data` equal to its bits 11..0, zero-extended.
- R8: A plain data word is pushed with its 23 data bits. `out_eoe` copies bit 26, and a word with bit 26 set ends the event. At most one of `out_gap`, `out_empty` and `out_eoe` is high on any push.
- R9: An event that ends on a word with the terminator bit (27) set returns the shared offset to 0, so the next trigger replays the first event. Otherwise the offset continues with the word after the event.
- R10: An event whose first word has the empty bit set produces a single push with `out_empty`=1 and `out_data`=0. That one word is the whole event.
- R11: While `out_full` is 1, no entry is pushed and the sequencer holds. Every entry is pushed exactly once, in order.
- R12: Turning transmission off returns the shared offset to 0 and discards queued triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmission enable |
| trig_valid | input | 1 | Trigger strobe |
| trig_buf | input | 2 | Bank number of the trigger |
| trig_ready | output | 1 | Trigger queue can accept |
| host_addr_clr | input | 1 | Clear host address |
| host_wr | input | 1 | Write and advance |
| host_wdata | input | 28 | Host write word |
| host_rd | input | 1 | Read and advance |
| host_rdata | output | 28 | Readback word |
| host_rvalid | output | 1 | Readback word valid |
| out_full | input | 1 | Output FIFO full |
| out_push | output | 1 | Push an entry |
| out_data | output | 23 | Entry data or gap value |
| out_eoe | output | 1 | Entry closes an event |
| out_empty | output | 1 | Empty-event marker |
| out_gap | output | 1 | Gap request |
| dly_valid | output | 1 | Event delay strobe |
| dly_value | output | 12 | Event delay value |
| dly_buf | output | 2 | Bank of the delayed event |

## Verification
Host readback data is valid one cycle after `host_rd`. The bench checks it on the following falling edge. A delay strobe comes three cycles after trigger acceptance, because the queue write, the pop and the registered memory read each take one cycle. The bench counts three falling edges from the trigger and checks that the strobe is absent one edge earlier. Push timing varies with stalls, so pushes and delay strobes are collected by a monitor half a cycle after each falling edge, after `out_full` has settled. The collected sequence is then compared entry by entry against a stream computed from the loaded pattern.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  localparam int DATA_W = 23;
  localparam int WORD_W = DATA_W + 5;

  // bit 27 term, 26 eoe, 25 empty, 24 gap, 23 delay, 22..0 data
  typedef struct packed {
    logic              term;
    logic              eoe;
    logic              empty;
    logic              gap;
    logic              dly;
    logic [DATA_W-1:0] data;
  } pat_word_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_DECODE} seq_state_e;

  // widen a small field of the data bits to full data width
  function automatic logic [DATA_W-1:0] field_ext(input logic [DATA_W-1:0] d, input int vw);
    logic [DATA_W-1:0] m;
    m = (DATA_W'(1) << vw) - DATA_W'(1);
    return d & m;
  endfunction

  // next offset after an event closes
  function automatic logic [9:0] next_off(input logic [9:0] off, input logic wrap);
    return wrap ? 10'd0 : off + 10'd1;
  endfunction
endpackage

// File: rtl/evt_trig_fifo.sv
module evt_trig_fifo #(
  parameter int W     = 2,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [AW-1:0] rd_p, wr_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slots[rd_p];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) begin
        slots[wr_p] <= din;
        wr_p        <= bump(wr_p);
      end
      if (do_pop) rd_p <= bump(rd_p);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/evt_pattern_mem.sv
module evt_pattern_mem #(
  parameter int AW = 12,
  parameter int W  = 28
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 1 << AW;
  logic [W-1:0] mem [0:N-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evt_host_port.sv
module evt_host_port #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          addr_clr,
  input  logic          wr,
  input  logic          rd,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic          rvalid
);
  logic active;
  assign active = !tx_en;
  assign we     = active && wr && !addr_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= active && rd && !addr_clr && !wr;
      if (active) begin
        if (addr_clr)      addr <= '0;
        else if (wr || rd) addr <= addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/evt_seq_ctrl.sv
module evt_seq_ctrl
  import evt_seq_pkg::*;
#(
  parameter int SEL_W = 2,
  parameter int OFF_W = 10,
  parameter int VAL_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tx_en,
  input  logic                   trig_empty,
  input  logic [SEL_W-1:0]       trig_buf,
  output logic                   trig_pop,
  input  pat_word_t              word,
  output logic [SEL_W+OFF_W-1:0] rd_addr,
  input  logic                   out_full,
  output logic                   out_push,
  output logic [DATA_W-1:0]      out_data,
  output logic                   out_eoe,
  output logic                   out_empty,
  output logic                   out_gap,
  output logic                   dly_valid,
  output logic [VAL_W-1:0]       dly_value,
  output logic [SEL_W-1:0]       dly_buf,
  output logic                   event_done,
  output logic                   wrap_evt,
  output logic [OFF_W-1:0]       off_q
);
  seq_state_e       state;
  logic [SEL_W-1:0] cur_buf;
  logic             first;

  logic in_dec, is_empty_evt, is_gap, is_data, needs_push, stall, ends;

  assign in_dec       = tx_en && (state == SQ_DECODE);
  assign is_empty_evt = first && word.empty;
  assign is_gap       = word.gap && !word.dly && !is_empty_evt;
  assign is_data      = !is_empty_evt && !word.dly && !word.gap;
  assign needs_push   = is_empty_evt || is_gap || is_data;
  assign stall        = needs_push && out_full;
  assign ends         = is_empty_evt || (is_data && word.eoe);

  assign trig_pop   = tx_en && (state == SQ_IDLE) && !trig_empty;
  assign rd_addr    = {cur_buf, off_q};
  assign out_push   = in_dec && needs_push && !out_full;
  assign out_gap    = is_gap;
  assign out_empty  = is_empty_evt;
  assign out_eoe    = is_data && word.eoe;
  assign out_data   = is_gap ? field_ext(word.data, VAL_W)
                    : (is_empty_evt ? '0 : word.data);
  assign dly_valid  = in_dec && first && word.dly && !word.empty;
  assign dly_value  = word.data[VAL_W-1:0];
  assign dly_buf    = cur_buf;
  assign event_done = in_dec && !stall && ends;
  assign wrap_evt   = event_done && word.term;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      state   <= SQ_IDLE;
      off_q   <= '0;
      first   <= 1'b0;
      cur_buf <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (!trig_empty) begin
          cur_buf <= trig_buf;
          first   <= 1'b1;
          state   <= SQ_WAIT;
        end
        SQ_WAIT: state <= SQ_DECODE;
        SQ_DECODE: if (!stall) begin
          first <= 1'b0;
          if (ends) begin
            off_q <= OFF_W'(next_off(10'(off_q), word.term));
            state <= SQ_IDLE;
          end else begin
            off_q <= off_q + OFF_W'(1);
            state <= SQ_WAIT;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_pattern_seq.sv
module evt_pattern_seq
  import evt_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SEL_W      = 2,
  parameter int VAL_W      = 12,
  parameter int TRIG_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              trig_valid,
  input  logic [SEL_W-1:0]  trig_buf,
  output logic              trig_ready,
  input  logic              host_addr_clr,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_rd,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              out_full,
  output logic              out_push,
  output logic [DATA_W-1:0] out_data,
  output logic              out_eoe,
  output logic              out_empty,
  output logic              out_gap,
  output logic              dly_valid,
  output logic [VAL_W-1:0]  dly_value,
  output logic [SEL_W-1:0]  dly_buf
);
  localparam int OFF_W = ADDR_W - SEL_W;

  logic [SEL_W-1:0]  q_buf;
  logic              q_empty, q_full, q_pop;
  logic [ADDR_W-1:0] host_addr, seq_addr, mem_raddr;
  logic              host_we;
  logic [WORD_W-1:0] mem_q;
  logic              event_done, wrap_evt;
  logic [OFF_W-1:0]  seq_off;

  assign trig_ready = tx_en && !q_full;
  assign mem_raddr  = tx_en ? seq_addr : host_addr;
  assign host_rdata = mem_q;

  evt_trig_fifo #(.W(SEL_W), .DEPTH(TRIG_DEPTH)) trig_q_i (
    .clk(clk), .rst_n(rst_n), .flush(!tx_en),
    .push(trig_valid && tx_en), .din(trig_buf),
    .pop(q_pop), .dout(q_buf), .empty(q_empty), .full(q_full)
  );

  evt_host_port #(.AW(ADDR_W)) host_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .addr_clr(host_addr_clr), .wr(host_wr), .rd(host_rd),
    .addr(host_addr), .we(host_we), .rvalid(host_rvalid)
  );

  evt_pattern_mem #(.AW(ADDR_W), .W(WORD_W)) mem_i (
    .clk(clk), .we(host_we), .waddr(host_addr), .wdata(host_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  evt_seq_ctrl #(.SEL_W(SEL_W), .OFF_W(OFF_W), .VAL_W(VAL_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
    .trig_empty(q_empty), .trig_buf(q_buf), .trig_pop(q_pop),
    .word(pat_word_t'(mem_q)), .rd_addr(seq_addr),
    .out_full(out_full), .out_push(out_push), .out_data(out_data),
    .out_eoe(out_eoe), .out_empty(out_empty), .out_gap(out_gap),
    .dly_valid(dly_valid), .dly_value(dly_value), .dly_buf(dly_buf),
    .event_done(event_done), .wrap_evt(wrap_evt), .off_q(seq_off)
  );
endmodule

// File: rtl/evt_seq_chk.sv
module evt_seq_chk #(
  parameter int OFF_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             out_full,
  input logic             out_push,
  input logic             out_gap,
  input logic             out_empty,
  input logic             out_eoe,
  input logic             dly_valid,
  input logic             host_rvalid,
  input logic             event_done,
  input logic             wrap_evt,
  input logic [OFF_W-1:0] off_q
);
  // R11
  push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> !out_full);
  // R8
  tag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_push |-> $onehot0({out_gap, out_empty, out_eoe}));
  // R6
  dly_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_valid |-> !out_push);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!out_push && !dly_valid));
  // R3
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> !$past(tx_en));
  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (off_q == '0));
  // R9
  cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_done && !wrap_evt && tx_en) |=> (!tx_en || off_q == $past(off_q) + OFF_W'(1)));
  // R12
  off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (off_q == '0));
endmodule

bind evt_pattern_seq evt_seq_chk #(.OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .out_full(out_full),
  .out_push(out_push), .out_gap(out_gap), .out_empty(out_empty),
  .out_eoe(out_eoe), .dly_valid(dly_valid), .host_rvalid(host_rvalid),
  .event_done(event_done), .wrap_evt(wrap_evt), .off_q(seq_off)
);

// File: tb/evt_pattern_seq_tb.sv
module evt_pattern_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic trig_valid = 1'b0;
  logic [1:0] trig_buf = '0;
  logic trig_ready;
  logic host_addr_clr = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [27:0] host_wdata = '0;
  logic [27:0] host_rdata;
  logic host_rvalid;
  logic out_full = 1'b0;
  logic out_push, out_eoe, out_empty, out_gap, dly_valid;
  logic [22:0] out_data;
  logic [11:0] dly_value;
  logic [1:0] dly_buf;

  int checks = 0, errors = 0;
  logic stall_on = 1'b0;
  int cyc = 0;

  logic [25:0] exp_q [0:255];
  logic [25:0] got_q [0:255];
  logic [13:0] dexp [0:63];
  logic [13:0] dgot [0:63];
  int en = 0, gn = 0, den = 0, dgn = 0;
  int evt_idx = 0;

  always #10 clk = ~clk;

  evt_pattern_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .trig_valid(trig_valid),
    .trig_buf(trig_buf), .trig_ready(trig_ready), .host_addr_clr(host_addr_clr),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .out_full(out_full),
    .out_push(out_push), .out_data(out_data), .out_eoe(out_eoe),
    .out_empty(out_empty), .out_gap(out_gap), .dly_valid(dly_valid),
    .dly_value(dly_value), .dly_buf(dly_buf)
  );

  function automatic logic [22:0] dval(input int b, input int o);
    return 23'(32'h100000 | (b << 8) | o);
  endfunction

  function automatic logic [27:0] pat_word(input int a);
    int b, o;
    b = a / 1024;
    o = a % 1024;
    case (o)
      0: return {5'b00001, 23'(5 + b)};
      3: return {5'b00010, 23'(7 + b)};
      4: return {5'b01000, dval(b, 4)};
      5: return {5'b00100, 23'h7ABC};
      6: return {5'b00001, 23'(20 + b)};
      8: return {5'b11000, dval(b, 8)};
      1, 2, 7: return {5'b00000, dval(b, o)};
      default: return {5'b00000, 23'((a * 37 + 11) & 32'h7FFFFF)};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // expected stream for one event of bank b
  task automatic model_event(input int b);
    int e;
    e = evt_idx % 3;
    evt_idx++;
    case (e)
      0: begin
        dexp[den++] = {2'(b), 12'(5 + b)};
        exp_q[en++] = {3'b000, dval(b, 1)};
        exp_q[en++] = {3'b000, dval(b, 2)};
        exp_q[en++] = {3'b100, 23'(7 + b)};
        exp_q[en++] = {3'b001, dval(b, 4)};
      end
      1: exp_q[en++] = {3'b010, 23'd0};
      default: begin
        dexp[den++] = {2'(b), 12'(20 + b)};
        exp_q[en++] = {3'b000, dval(b, 7)};
        exp_q[en++] = {3'b001, dval(b, 8)};
      end
    endcase
  endtask

  task automatic push_trig(input int b);
    @(negedge clk);
    while (!trig_ready) @(negedge clk);
    trig_valid = 1'b1;
    trig_buf = 2'(b);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic compare_phase(input string tag);
    check(gn == en, tag, gn, en);
    check(dgn == den, "R6", dgn, den);
    for (int i = 0; i < en && i < gn; i++) begin
      string r;
      if (stall_on) r = "R11";
      else if (exp_q[i][25]) r = "R7";
      else if (exp_q[i][24]) r = "R10";
      else if (exp_q[i][23]) r = "R8";
      else r = "R5";
      check(got_q[i] == exp_q[i], r, int'(got_q[i]), int'(exp_q[i]));
    end
    for (int i = 0; i < den && i < dgn; i++)
      check(dgot[i] == dexp[i], "R6", int'(dgot[i]), int'(dexp[i]));
    en = 0; gn = 0; den = 0; dgn = 0;
  endtask

  // stall driver
  initial forever begin
    @(negedge clk);
    cyc++;
    out_full = stall_on ? ((cyc % 3) != 0) : 1'b0;
  end

  // monitor, half a cycle after the falling edge
  initial forever begin
    @(negedge clk);
    #5;
    if (out_push && gn < 256) got_q[gn++] = {out_gap, out_empty, out_eoe, out_data};
    if (dly_valid && dgn < 64) dgot[dgn++] = {dly_buf, dly_value};
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    int mism;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(trig_ready == 0, "R1", trig_ready, 0);
    check(out_push == 0, "R1", out_push, 0);
    check(dly_valid == 0, "R1", dly_valid, 0);
    check(host_rvalid == 0, "R1", host_rvalid, 0);

    // R2 load all 4096 words
    host_addr_clr = 1'b1;
    @(negedge clk);
    host_addr_clr = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      host_wr = 1'b1;
      host_wdata = pat_word(a);
      @(negedge clk);
    end
    host_wr = 1'b0;
    host_addr_clr = 1'b1;
    @(negedge clk);
    host_addr_clr = 1'b0;
    mism = 0;
    host_rd = 1'b1;
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      if (a == 4095) host_rd = 1'b0;
      if (!host_rvalid || host_rdata != pat_word(a)) mism++;
    end
    check(mism == 0, "R2", mism, 0);
    @(negedge clk);
    check(host_rvalid == 0, "R2", host_rvalid, 0);

    // R4 trigger while disabled is dropped
    trig_valid = 1'b1;
    trig_buf = 2'd1;
    @(negedge clk);
    trig_valid = 1'b0;
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    check(gn == 0 && dgn == 0, "R4", gn + dgn, 0);

    // R3 host strobes while enabled (address is back at 0)
    host_wr = 1'b1;
    host_wdata = 28'hFFFFFFF;
    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    check(host_rvalid == 0, "R3", host_rvalid, 0);

    // R5 R9 sweep: every bank meets every event slot
    for (int k = 0; k < 12; k++) begin
      model_event(k % 4);
      push_trig(k % 4);
    end
    repeat (400) @(negedge clk);
    // R9: fourth trigger (bank 3) must replay the first event after the terminator
    check(dgot[2] == {2'd3, 12'd8}, "R9", int'(dgot[2]), int'({2'd3, 12'd8}));
    compare_phase("R5");

    // R11 stall phase
    stall_on = 1'b1;
    for (int k = 0; k < 12; k++) begin
      model_event((k * 3) % 4);
      push_trig((k * 3) % 4);
    end
    repeat (1200) @(negedge clk);
    compare_phase("R11");
    stall_on = 1'b0;

    // R12 disable then re-enable restarts at the first event
    model_event(0);
    push_trig(0);
    repeat (2) @(negedge clk);
    tx_en = 1'b0;
    repeat (3) @(negedge clk);
    en = 0; den = 0; gn = 0; dgn = 0;
    tx_en = 1'b1;
    evt_idx = 0;
    @(negedge clk);
    // R6 latency: trigger accepted at the next rising edge
    model_event(2);
    trig_valid = 1'b1;
    trig_buf = 2'd2;
    @(negedge clk);
    trig_valid = 1'b0;
    @(negedge clk);
    check(dly_valid == 0, "R6", dly_valid, 0);
    @(negedge clk);
    check(dly_valid == 1, "R6", dly_valid, 1);
    check(dly_value == 12'd7, "R12", dly_value, 7);
    check(dly_buf == 2'd2, "R6", dly_buf, 2);
    repeat (60) @(negedge clk);
    compare_phase("R12");

    // R3 earlier write must not have landed
    tx_en = 1'b0;
    @(negedge clk);
    host_addr_clr = 1'b1;
    @(negedge clk);
    host_addr_clr = 1'b0;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    check(host_rvalid == 1, "R2", host_rvalid, 1);
    check(host_rdata == pat_word(0), "R3", int'(host_rdata), int'(pat_word(0)));
    finish_up();
  end
endmodule